// File: doc/BRIEF.md
# Programmed I/O Transfer Decoder

This block decodes the input/output transfer class of instructions for a 12-bit accumulator processor. It serves a small bank of simple peripherals. When the processor presents an instruction with `instr_valid`, the block picks out the addressed device and runs the three function bits as separate micro-actions. It registers the results for the processor to use: a skip request, an accumulator write, a start strobe to the device, and a data word for output devices.

Each peripheral slot keeps a ready flag and a data register. An external `dev_event` pulse sets the slot's ready flag and latches its input word. A transfer instruction on that slot clears the flag. Device code zero never reaches a peripheral. It controls the interrupt enable instead. The interrupt request is the OR of every ready flag, gated by that enable.

Top module: `pio_xfer_decoder`

## Requirements
- R1: Only words with `instr[11:9]` equal to 3'b110 are decoded. For any other opcode, `skip`, `acc_write` and `dev_start` stay low, and no flag or enable changes.
- R2: Device code `instr[8:3]` = k with 1 <= k <= NUM_DEV addresses slot k-1. Each transfer pulses at most one `dev_start` bit, bit k-1, for one cycle in the cycle after the instruction. Codes above NUM_DEV address no slot: they never skip and never start, but the clear bit still acts.
- R3: With `instr[0]` set, `skip` is high in the cycle after the instruction exactly when the addressed slot's ready flag was set before this instruction.
- R4: With `instr[1]` set, the accumulator value is first replaced by zero. Without an input transfer, the block then raises `acc_write` with `acc_out` = 0.
- R5: With `instr[2]` set on an input slot (IN_MASK bit = 1), `acc_out` is the slot's data word ORed into the AC value left after the clear step, and `acc_write` is high. The slot's ready flag is cleared.
- R6: With `instr[2]` set on an output slot, `dev_out_word` takes the AC value left after the clear step. The slot's ready flag is cleared, and `acc_write` is high only if `instr[1]` is also set.
- R7: The micro-actions run in a fixed order: skip test, then AC clear, then transfer. The skip therefore sees the flag before the transfer clears it, and an output slot sends zero when the clear bit is set.
- R8: A `dev_event[i]` pulse sets ready flag i and latches slice i of `dev_in_word`. When an event and a transfer on the same slot fall in one cycle, the flag ends set.
- R9: Code 6001 (octal) sets `int_enable`, and 6002 clears it. Any device-zero instruction leaves `skip`, `acc_write` and `dev_start` low. Other device-zero function values leave the enable unchanged.
- R10: `irq` is high exactly when `int_enable` is set and at least one ready flag is set.
- R11: While reset is held, all flags, `int_enable`, `skip`, `acc_write`, `dev_start`, `acc_out`, `dev_out_word` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | WORD_W | Instruction word, bit 11 most significant |
| acc_in | input | WORD_W | Current accumulator value |
| dev_event | input | NUM_DEV | Per-slot completion pulse; sets ready flag |
| dev_in_word | input | NUM_DEV*WORD_W | Per-slot input words, slot i at bits i*WORD_W upward |
| skip | output | 1 | Skip next instruction (one-cycle pulse) |
| acc_write | output | 1 | Load `acc_out` into the accumulator (pulse) |
| acc_out | output | WORD_W | New accumulator value |
| dev_start | output | NUM_DEV | One-hot start strobe to a slot |
| dev_out_word | output | WORD_W | Word sent to an output slot |
| int_enable | output | 1 | Interrupt enable state |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: four slots, with slots 0 and 2 as input devices and slots 1 and 3 as output devices. Both transfer directions and both clear/transfer orderings are therefore exercised on real slots. Device code 5 lies just past the populated range, so the unpopulated-code path is reachable with no extra parameters. Event and transfer collisions, device-zero functions other than enable and disable, and gated versus ungated interrupts all occur with these values.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
// Shared constants and the decoded-instruction record for the
// programmed I/O transfer decoder. Assumes the 12-bit word layout
// opcode[11:9], device[8:3], function[2:0].
package pio_pkg;
    localparam logic [2:0] OPC_IO  = 3'b110;
    localparam logic [2:0] FN_IEN  = 3'b001;
    localparam logic [2:0] FN_IDIS = 3'b010;

    typedef struct packed {
        logic io_dev;   // I/O opcode, nonzero device code
        logic sel_hit;  // a populated slot is addressed
        logic f_skip;   // function bit 0
        logic f_clr;    // function bit 1
        logic f_xfer;   // function bit 2
        logic ien_set;  // device-zero enable
        logic ien_clr;  // device-zero disable
    } pio_dec_t;
endpackage

// File: rtl/pio_instr_decode.sv
`timescale 1ns/1ps
// Combinational decode of one instruction word into micro-action
// flags and a one-hot slot select. Assumes slot i answers to device
// code i+1 and that device code zero is reserved for the processor.
module pio_instr_decode
    import pio_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int NUM_DEV = 4
) (
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    output pio_dec_t          dec,
    output logic [NUM_DEV-1:0] dev_sel
);
    localparam int OPC_W  = 3;
    localparam int FN_W   = 3;
    localparam int CODE_W = WORD_W - OPC_W - FN_W;

    logic [OPC_W-1:0]  opc;
    logic [CODE_W-1:0] code;
    logic [FN_W-1:0]   fn;
    logic              is_io;

    assign opc   = instr[WORD_W-1 -: OPC_W];
    assign code  = instr[FN_W +: CODE_W];
    assign fn    = instr[FN_W-1:0];
    assign is_io = instr_valid && (opc == OPC_IO);

    // One comparator per populated slot
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign dev_sel[i] = is_io && (code == CODE_W'(i + 1));
    end

    // Assemble the micro-action record
    always_comb begin
        dec.io_dev  = is_io && (code != '0);
        dec.sel_hit = |dev_sel;
        dec.f_skip  = fn[0];
        dec.f_clr   = fn[1];
        dec.f_xfer  = fn[2];
        dec.ien_set = is_io && (code == '0) && (fn == FN_IEN);
        dec.ien_clr = is_io && (code == '0) && (fn == FN_IDIS);
    end
endmodule

// File: rtl/pio_dev_bank.sv
`timescale 1ns/1ps
// Bank of peripheral slots, each holding a ready flag and a data word.
// An event sets the flag and latches the slot's input word. A transfer
// clears the flag, and an event in the same cycle takes priority.
// Assumes dev_sel is one-hot or zero.
module pio_dev_bank #(
    parameter int                 WORD_W  = 12,
    parameter int                 NUM_DEV = 4,
    parameter logic [NUM_DEV-1:0] IN_MASK = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV-1:0]        dev_sel,
    input  logic                      xfer_go,
    input  logic [NUM_DEV-1:0]        dev_event,
    input  logic [NUM_DEV*WORD_W-1:0] dev_in_word,
    output logic [NUM_DEV-1:0]        ready_vec,
    output logic                      sel_ready,
    output logic [WORD_W-1:0]         sel_data,
    output logic                      sel_is_input
);
    logic [WORD_W-1:0] data_q [NUM_DEV];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_slot
        // Ready flag: event sets, transfer on this slot clears
        always_ff @(posedge clk) begin
            if (!rst_n)
                ready_vec[i] <= 1'b0;
            else if (dev_event[i])
                ready_vec[i] <= 1'b1;
            else if (xfer_go && dev_sel[i])
                ready_vec[i] <= 1'b0;
        end

        // Data word: latched from the slot's input slice on each event
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[i] <= '0;
            else if (dev_event[i])
                data_q[i] <= dev_in_word[i*WORD_W +: WORD_W];
        end
    end

    // Select the addressed slot's flag, word and direction
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NUM_DEV; i++)
            if (dev_sel[i]) sel_data = sel_data | data_q[i];
        sel_ready    = |(ready_vec & dev_sel);
        sel_is_input = |(IN_MASK & dev_sel);
    end
endmodule

// File: rtl/pio_result.sv
`timescale 1ns/1ps
// Runs the micro-actions in the order skip, clear, transfer and
// registers the processor-facing results plus the interrupt enable.
// Assumes the slot flags it sees are the values before this instruction.
module pio_result
    import pio_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pio_dec_t           dec,
    input  logic [NUM_DEV-1:0] dev_sel,
    input  logic               sel_ready,
    input  logic [WORD_W-1:0]  sel_data,
    input  logic               sel_is_input,
    input  logic [WORD_W-1:0]  acc_in,
    output logic               skip,
    output logic               acc_write,
    output logic [WORD_W-1:0]  acc_out,
    output logic [NUM_DEV-1:0] dev_start,
    output logic [WORD_W-1:0]  dev_out_word,
    output logic               int_en
);
    logic              xfer_go, ac_clr, in_xfer, out_xfer;
    logic [WORD_W-1:0] ac_after_clr;

    // Stage the ordered micro-actions for this instruction
    always_comb begin
        xfer_go      = dec.sel_hit && dec.f_xfer;
        ac_clr       = dec.io_dev && dec.f_clr;
        ac_after_clr = ac_clr ? '0 : acc_in;
        in_xfer      = xfer_go && sel_is_input;
        out_xfer     = xfer_go && !sel_is_input;
    end

    // Register pulses and data words seen by the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip         <= 1'b0;
            acc_write    <= 1'b0;
            acc_out      <= '0;
            dev_start    <= '0;
            dev_out_word <= '0;
        end else begin
            skip      <= dec.sel_hit && dec.f_skip && sel_ready;
            acc_write <= ac_clr || in_xfer;
            dev_start <= xfer_go ? dev_sel : '0;
            if (ac_clr || in_xfer)
                acc_out <= in_xfer ? (ac_after_clr | sel_data) : ac_after_clr;
            if (out_xfer)
                dev_out_word <= ac_after_clr;
        end
    end

    // Interrupt enable driven by device-zero functions
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_en <= 1'b0;
        else if (dec.ien_set)
            int_en <= 1'b1;
        else if (dec.ien_clr)
            int_en <= 1'b0;
    end
endmodule

// File: rtl/pio_xfer_decoder.sv
`timescale 1ns/1ps
// Top of the programmed I/O transfer decoder: instruction decode, slot
// bank and ordered result stage. Results appear one cycle after the
// instruction. irq follows the flags and enable with no extra delay.
module pio_xfer_decoder
    import pio_pkg::*;
#(
    parameter int                 WORD_W  = 12,
    parameter int                 NUM_DEV = 4,
    parameter logic [NUM_DEV-1:0] IN_MASK = 4'b0101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [WORD_W-1:0]         instr,
    input  logic [WORD_W-1:0]         acc_in,
    input  logic [NUM_DEV-1:0]        dev_event,
    input  logic [NUM_DEV*WORD_W-1:0] dev_in_word,
    output logic                      skip,
    output logic                      acc_write,
    output logic [WORD_W-1:0]         acc_out,
    output logic [NUM_DEV-1:0]        dev_start,
    output logic [WORD_W-1:0]         dev_out_word,
    output logic                      int_enable,
    output logic                      irq
);
    pio_dec_t           dec;
    logic [NUM_DEV-1:0] dev_sel;
    logic [NUM_DEV-1:0] ready_vec;
    logic               sel_ready, sel_is_input;
    logic [WORD_W-1:0]  sel_data;

    pio_instr_decode #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV)) u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec),
        .dev_sel     (dev_sel)
    );

    pio_dev_bank #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV), .IN_MASK(IN_MASK)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_sel      (dev_sel),
        .xfer_go      (dec.sel_hit && dec.f_xfer),
        .dev_event    (dev_event),
        .dev_in_word  (dev_in_word),
        .ready_vec    (ready_vec),
        .sel_ready    (sel_ready),
        .sel_data     (sel_data),
        .sel_is_input (sel_is_input)
    );

    pio_result #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec          (dec),
        .dev_sel      (dev_sel),
        .sel_ready    (sel_ready),
        .sel_data     (sel_data),
        .sel_is_input (sel_is_input),
        .acc_in       (acc_in),
        .skip         (skip),
        .acc_write    (acc_write),
        .acc_out      (acc_out),
        .dev_start    (dev_start),
        .dev_out_word (dev_out_word),
        .int_en       (int_enable)
    );

    // Interrupt request: any ready slot, gated by the enable
    assign irq = int_enable && (|ready_vec);
endmodule

// File: rtl/pio_xfer_decoder_chk.sv
`timescale 1ns/1ps
// Property checker for the transfer decoder, bound to every instance.
module pio_xfer_decoder_chk #(
    parameter int WORD_W  = 12,
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [WORD_W-1:0]  instr,
    input logic               skip,
    input logic               acc_write,
    input logic [WORD_W-1:0]  acc_out,
    input logic [NUM_DEV-1:0] dev_start,
    input logic               int_enable,
    input logic               irq
);
    logic is_io, code_zero;
    assign is_io     = instr_valid && (instr[11:9] == 3'b110);
    assign code_zero = (instr[8:3] == 6'd0);

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!skip && !acc_write && dev_start == '0 && !int_enable && !irq));

    p_start_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_start));

    p_other_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_io) |=> (!skip && !acc_write && dev_start == '0));

    p_skip_after_instr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(is_io));

    p_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_io && !code_zero && instr[1] && !instr[2]) |=> (acc_write && acc_out == '0));

    p_dev_zero_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_io && code_zero) |=> (!skip && !acc_write && dev_start == '0));

    p_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_io && instr[8:0] == 9'o001) |=> int_enable);

    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_io && instr[8:0] == 9'o002) |=> (!int_enable && !irq));
endmodule

bind pio_xfer_decoder pio_xfer_decoder_chk #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .skip        (skip),
    .acc_write   (acc_write),
    .acc_out     (acc_out),
    .dev_start   (dev_start),
    .int_enable  (int_enable),
    .irq         (irq)
);

// File: tb/pio_xfer_decoder_test.sv
`timescale 1ns/1ps
module pio_xfer_decoder_test;
    localparam int W = 12;
    localparam int N = 4;
    localparam logic [N-1:0] INM = 4'b0101;

    typedef struct {
        logic          skip;
        logic          accw;
        logic [W-1:0]  acc;
        logic [N-1:0]  start;
        logic          chk_out;
        logic [W-1:0]  outw;
        string         req;
    } exp_t;

    logic clk = 0, rst_n = 0, instr_valid = 0;
    logic [W-1:0] instr = '0, acc_in = '0;
    logic [N-1:0] dev_event = '0;
    logic [N*W-1:0] dev_in_word = '0;
    logic skip, acc_write, int_enable, irq;
    logic [W-1:0] acc_out, dev_out_word;
    logic [N-1:0] dev_start;

    int total = 0, bad = 0;
    exp_t q[$];
    logic m_ie = 0;
    logic [N-1:0] m_flag = '0;
    logic [W-1:0] m_data [N];
    bit done = 0;

    always #4 clk = ~clk;

    pio_xfer_decoder #(.WORD_W(W), .NUM_DEV(N), .IN_MASK(INM)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .acc_in(acc_in), .dev_event(dev_event), .dev_in_word(dev_in_word),
        .skip(skip), .acc_write(acc_write), .acc_out(acc_out),
        .dev_start(dev_start), .dev_out_word(dev_out_word),
        .int_enable(int_enable), .irq(irq));

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(bit v, logic [W-1:0] ins, logic [W-1:0] ac,
                        logic [N-1:0] ev, logic [W-1:0] evw, string req);
        exp_t e;
        logic [W-1:0] a;
        int idx;
        @(negedge clk);
        instr_valid = v; instr = ins; acc_in = ac; dev_event = ev;
        for (int i = 0; i < N; i++) dev_in_word[i*W +: W] = ev[i] ? evw : '0;
        e = '{skip:0, accw:0, acc:'0, start:'0, chk_out:0, outw:'0, req:req};
        if (v && ins[11:9] == 3'b110) begin
            if (ins[8:3] == 0) begin
                if (ins[2:0] == 3'd1) m_ie = 1;
                else if (ins[2:0] == 3'd2) m_ie = 0;
            end else begin
                a = ins[1] ? '0 : ac;
                e.accw = ins[1];
                if (ins[8:3] <= N) begin
                    idx = int'(ins[8:3]) - 1;
                    e.skip = ins[0] & m_flag[idx];
                    if (ins[2]) begin
                        e.start[idx] = 1'b1;
                        if (INM[idx]) begin a = a | m_data[idx]; e.accw = 1; end
                        else begin e.chk_out = 1; e.outw = a; end
                        m_flag[idx] = 1'b0;
                    end
                end
                e.acc = a;
            end
        end
        for (int i = 0; i < N; i++)
            if (ev[i]) begin m_flag[i] = 1'b1; m_data[i] = evw; end
        if (v) q.push_back(e);
    endtask

    // Monitor: compare each cycle's outputs just after the edge
    always @(posedge clk) begin
        logic was_v;
        exp_t e;
        was_v = instr_valid;
        #1;
        if (rst_n && !done) begin
            if (was_v && q.size() > 0) begin
                e = q.pop_front();
                check(e.req, "skip", W'(skip), W'(e.skip));
                check(e.req, "acc_write", W'(acc_write), W'(e.accw));
                if (e.accw) check(e.req, "acc_out", acc_out, e.acc);
                check(e.req, "dev_start", W'(dev_start), W'(e.start));
                if (e.chk_out) check(e.req, "dev_out_word", dev_out_word, e.outw);
            end else begin
                check("R1", "idle skip", W'(skip), '0);
                check("R2", "idle dev_start", W'(dev_start), '0);
            end
            check("R9", "int_enable", W'(int_enable), W'(m_ie));
            check("R10", "irq", W'(irq), W'(m_ie & (|m_flag)));
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state observed while reset is held
        check("R11", "skip", W'(skip), '0);
        check("R11", "acc_write", W'(acc_write), '0);
        check("R11", "dev_start", W'(dev_start), '0);
        check("R11", "acc_out", acc_out, '0);
        check("R11", "dev_out_word", dev_out_word, '0);
        check("R11", "irq/int_enable", W'({irq, int_enable}), '0);
        rst_n = 1;
        step(0, '0, '0, '0, '0, "R11");
        // R1: other opcodes are ignored, even with a ready slot
        step(0, '0, '0, 4'b0001, 12'o123, "R8");
        step(1, 12'o7200, 12'o777, '0, '0, "R1");
        step(1, 12'o1017, 12'o777, '0, '0, "R1");
        step(1, 12'o6011, 12'o0, '0, '0, "R3");      // ready slot 0 skips
        step(1, 12'o6031, 12'o0, '0, '0, "R3");      // slot 2 not ready
        // R9 / R10: enable raises irq while slot 0 is ready
        step(1, 12'o6001, 12'o0, '0, '0, "R9");
        // R5 / R7: clear then input transfer on slot 0
        step(1, 12'o6016, 12'o4444, '0, '0, "R5");
        step(1, 12'o6011, 12'o0, '0, '0, "R3");      // flag now clear
        // R5: no clear, OR into AC
        step(0, '0, '0, 4'b0001, 12'o055, "R8");
        step(1, 12'o6014, 12'o700, '0, '0, "R5");
        // R4: clear only
        step(1, 12'o6012, 12'o1234, '0, '0, "R4");
        // R6: output slot 3 without and with clear
        step(1, 12'o6044, 12'o321, '0, '0, "R6");
        step(1, 12'o6046, 12'o777, '0, '0, "R7");
        // R8: event and transfer on slot 1 in the same cycle
        step(1, 12'o6024, 12'o17, 4'b0010, 12'o0, "R8");
        step(1, 12'o6021, 12'o0, '0, '0, "R8");
        // R2: code 5 is unpopulated
        step(1, 12'o6051, 12'o0, '0, '0, "R2");
        step(1, 12'o6057, 12'o5555, '0, '0, "R2");
        // R7: all three bits on a ready input slot
        step(0, '0, '0, 4'b0100, 12'o3210, "R8");
        step(1, 12'o6037, 12'o7777, '0, '0, "R7");
        step(1, 12'o6031, 12'o0, '0, '0, "R7");
        // R9: device zero with other functions, then disable
        step(1, 12'o6007, 12'o123, '0, '0, "R9");
        step(1, 12'o6002, 12'o0, '0, '0, "R10");
        step(1, 12'o6021, 12'o0, '0, '0, "R3");
        step(0, '0, '0, '0, '0, "R1");
        step(0, '0, '0, '0, '0, "R1");
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule